// File: doc/BRIEF.md
# Region-Masked Completion Interrupt Aggregator

This block gathers transfer-completion events from a 64-channel DMA engine and turns them into four region interrupt lines. Each line belongs to one processor or bus master that shares the engine. A completion arrives as a channel code on a valid/ready stream and marks that channel pending. Software enables channels globally and gives each region a channel mask. A region is active while at least one channel is pending, enabled and inside that region's mask.

Each region line gives a single-cycle pulse when its region goes from inactive to active. Completions that arrive while the region is already active add no further pulse. The completion stream is never back-pressured: `cmpl_ready` is held high, so a completion counts as taken in every cycle in which `cmpl_valid` is high.

Software reaches the block through a write port with one address and one data word per cycle, and a combinational read port. Every per-channel register is split into a low word (channels 0–31) and a high word (channels 32–63). Through the write port software clears pending bits, sets and clears enables, loads the region masks and asks for a region to be re-evaluated.

Top module: `cmpl_irq_agg`

## Requirements
- R1: After reset, every pending, enable and mask bit is 0, all `irq` bits are 0, every readable address returns 0 and `cmpl_ready` is 1.
- R2: A cycle with `cmpl_valid` high sets the pending bit of channel `cmpl_code`. Pending bits read at address 0 (channels 0–31, bit = code) and address 1 (channels 32–63, bit = code−32).
- R3: A write to address 2 (low word) or address 3 (high word) clears each pending bit whose data bit is 1. Data bits of 0 leave pending bits unchanged.
- R4: A write to address 6/7 sets, and a write to address 8/9 clears, each enable bit whose data bit is 1 (low/high word). The enable value reads at addresses 4/5.
- R5: The mask of region r is loaded directly by writes to address 10+2r (low word) and 11+2r (high word), and reads back at the same addresses.
- R6: Region r is active when any channel has pending, enable and region-r mask bits all 1. `irq[r]` is high for exactly one cycle, in the cycle after a clock edge at which region r changed from inactive to active.
- R7: A channel that becomes pending while region r is already active produces no pulse on `irq[r]`.
- R8: A write to address 18 with data bit r set makes `irq[r]` pulse in the next cycle if region r is active at that write. If region r is inactive, the write has no effect. Address 18 always reads 0.
- R9: When a completion and a pending-clear write hit the same channel in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmpl_valid | input | 1 | Completion event valid |
| cmpl_ready | output | 1 | Always 1; completions are never stalled |
| cmpl_code | input | 6 | Channel number of the completion |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| irq | output | 4 | Region interrupt pulses, one bit per region |

## Verification
The assertions assume that reset stays low for at least two clock edges. They also assume that `cmpl_code` and the write signals are stable and known at every edge where their strobes are high. The pending-clear check applies only in cycles without a competing completion, because R9 lets the set win there. The stimulus drives all inputs halfway between edges and holds reset for four cycles. It keeps write data sparse, so that regions switch between inactive and active often instead of staying active.

// File: rtl/cmpl_irq_pkg.sv
package cmpl_irq_pkg;
  localparam int CH_N   = 64;
  localparam int WORD_W = 32;
  localparam int REG_N  = 4;
  localparam int NWORD  = CH_N / WORD_W;
  localparam int CODE_W = $clog2(CH_N);
  localparam int ADDR_W = 5;

  // register map bases (word w of a block lives at base + w)
  localparam int A_PEND = 0;
  localparam int A_PCLR = A_PEND + NWORD;
  localparam int A_IEN  = A_PCLR + NWORD;
  localparam int A_ISET = A_IEN + NWORD;
  localparam int A_ICLR = A_ISET + NWORD;
  localparam int A_MASK = A_ICLR + NWORD;
  localparam int A_EVAL = A_MASK + REG_N * NWORD;
endpackage

// File: rtl/cmpl_pend_bank.sv
module cmpl_pend_bank #(
  parameter int CH_N   = 64,
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [CODE_W-1:0] set_code,
  input  logic [CH_N-1:0]   clr_mask,
  output logic [CH_N-1:0]   pend
);
  logic [CH_N-1:0] set_vec;
  logic [CH_N-1:0] pend_q;

  always_comb begin
    set_vec = '0;
    if (set_valid) set_vec[set_code] = 1'b1;
  end

  // a set in the same cycle as a clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | set_vec;
  end

  assign pend = pend_q;
endmodule

// File: rtl/cmpl_ien_bank.sv
module cmpl_ien_bank #(
  parameter int CH_N = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_N-1:0] set_mask,
  input  logic [CH_N-1:0] clr_mask,
  output logic [CH_N-1:0] ien
);
  logic [CH_N-1:0] ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else        ien_q <= (ien_q | set_mask) & ~clr_mask;
  end

  assign ien = ien_q;
endmodule

// File: rtl/cmpl_region_unit.sv
module cmpl_region_unit #(
  parameter int CH_N   = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_N/WORD_W-1:0] mask_we,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [CH_N-1:0]   pend,
  input  logic [CH_N-1:0]   ien,
  input  logic              eval_req,
  output logic [CH_N-1:0]   mask,
  output logic              cond,
  output logic              irq
);
  localparam int NW = CH_N / WORD_W;

  logic [CH_N-1:0] mask_q;
  logic            cond_q;
  logic            irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      for (int w = 0; w < NW; w++)
        if (mask_we[w]) mask_q[w*WORD_W +: WORD_W] <= wr_data;
    end
  end

  assign cond = |(pend & ien & mask_q);

  // pulse on a rising condition, or on request while the condition holds
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      irq_q  <= (cond & ~cond_q) | (eval_req & cond);
    end
  end

  assign mask = mask_q;
  assign irq  = irq_q;
endmodule

// File: rtl/cmpl_irq_agg.sv
module cmpl_irq_agg
  import cmpl_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl_valid,
  output logic              cmpl_ready,
  input  logic [CODE_W-1:0] cmpl_code,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic [REG_N-1:0]  irq
);
  logic [CH_N-1:0]  pend_q;
  logic [CH_N-1:0]  ien_q;
  logic [CH_N-1:0]  pclr_vec;
  logic [CH_N-1:0]  iset_vec;
  logic [CH_N-1:0]  iclr_vec;
  logic [CH_N-1:0]  reg_mask [REG_N];
  logic [REG_N-1:0] reg_cond;
  logic [REG_N-1:0] eval_req;

  assign cmpl_ready = 1'b1;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return int'(a) == target;
  endfunction

  // write decode into full-width write-1 vectors
  always_comb begin
    for (int w = 0; w < NWORD; w++) begin
      pclr_vec[w*WORD_W +: WORD_W] = (wr_en && hit(wr_addr, A_PCLR + w)) ? wr_data : '0;
      iset_vec[w*WORD_W +: WORD_W] = (wr_en && hit(wr_addr, A_ISET + w)) ? wr_data : '0;
      iclr_vec[w*WORD_W +: WORD_W] = (wr_en && hit(wr_addr, A_ICLR + w)) ? wr_data : '0;
    end
  end

  cmpl_pend_bank #(.CH_N(CH_N), .CODE_W(CODE_W)) pend_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (cmpl_valid),
    .set_code  (cmpl_code),
    .clr_mask  (pclr_vec),
    .pend      (pend_q)
  );

  cmpl_ien_bank #(.CH_N(CH_N)) ien_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_mask (iset_vec),
    .clr_mask (iclr_vec),
    .ien      (ien_q)
  );

  for (genvar r = 0; r < REG_N; r++) begin : g_region
    logic [NWORD-1:0] mwe;
    always_comb begin
      for (int w = 0; w < NWORD; w++)
        mwe[w] = wr_en && hit(wr_addr, A_MASK + r*NWORD + w);
    end
    assign eval_req[r] = wr_en && hit(wr_addr, A_EVAL) && wr_data[r];

    cmpl_region_unit #(.CH_N(CH_N), .WORD_W(WORD_W)) reg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_we  (mwe),
      .wr_data  (wr_data),
      .pend     (pend_q),
      .ien      (ien_q),
      .eval_req (eval_req[r]),
      .mask     (reg_mask[r]),
      .cond     (reg_cond[r]),
      .irq      (irq[r])
    );
  end

  // read mux; write-only and evaluate addresses return 0
  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (hit(rd_addr, A_PEND + w)) rd_data = pend_q[w*WORD_W +: WORD_W];
      if (hit(rd_addr, A_IEN + w))  rd_data = ien_q[w*WORD_W +: WORD_W];
      for (int r = 0; r < REG_N; r++)
        if (hit(rd_addr, A_MASK + r*NWORD + w)) rd_data = reg_mask[r][w*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/cmpl_irq_agg_chk.sv
module cmpl_irq_agg_chk
  import cmpl_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmpl_valid,
  input logic [CODE_W-1:0] cmpl_code,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WORD_W-1:0] rd_data,
  input logic [REG_N-1:0]  irq,
  input logic [CH_N-1:0]   pend,
  input logic [REG_N-1:0]  cond
);
  logic [REG_N-1:0] eval_seen;
  assign eval_seen = (wr_en && int'(wr_addr) == A_EVAL) ? wr_data[REG_N-1:0] : '0;

  // R2 R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |=> pend[$past(cmpl_code)]);

  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == A_PCLR && !cmpl_valid) |=> ((pend[WORD_W-1:0] & $past(wr_data)) == '0));

  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~$past(cond)) == '0);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & $past(cond, 2) & ~$past(eval_seen)) == '0);

  // R8
  eval_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) == A_EVAL) |-> (rd_data == '0));
endmodule

bind cmpl_irq_agg cmpl_irq_agg_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmpl_valid (cmpl_valid),
  .cmpl_code  (cmpl_code),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .irq        (irq),
  .pend       (pend_q),
  .cond       (reg_cond)
);

// File: tb/cmpl_irq_agg_tb_top.sv
module cmpl_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmpl_valid = 1'b0;
  logic        cmpl_ready;
  logic [5:0]  cmpl_code = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int pcnt [4];

  // reference state
  logic [63:0] m_pend, m_ien;
  logic [63:0] m_mask [4];
  logic [3:0]  m_prev, m_irq;

  always #10 clk = ~clk;

  cmpl_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .cmpl_valid(cmpl_valid), .cmpl_ready(cmpl_ready),
    .cmpl_code(cmpl_code), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] v = '0;
    if (a == 0) v = m_pend[31:0];
    if (a == 1) v = m_pend[63:32];
    if (a == 4) v = m_ien[31:0];
    if (a == 5) v = m_ien[63:32];
    if (a >= 10 && a <= 17) v = (a % 2 == 0) ? m_mask[(a-10)/2][31:0] : m_mask[(a-10)/2][63:32];
    return v;
  endfunction

  // behavioural model, one step per edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_ien = '0; m_prev = '0; m_irq = '0;
      for (int r = 0; r < 4; r++) m_mask[r] = '0;
    end else begin
      logic [3:0] act;
      for (int r = 0; r < 4; r++) begin
        act[r] = 1'b0;
        for (int c = 0; c < 64; c++)
          if (m_pend[c] && m_ien[c] && m_mask[r][c]) act[r] = 1'b1;
        m_irq[r] = (act[r] && !m_prev[r]) ||
                   (act[r] && wr_en && wr_addr == 5'd18 && wr_data[r]);
      end
      m_prev = act;
      if (wr_en) begin
        case (int'(wr_addr))
          2: m_pend[31:0]  = m_pend[31:0]  & ~wr_data;
          3: m_pend[63:32] = m_pend[63:32] & ~wr_data;
          6: m_ien[31:0]   = m_ien[31:0]   | wr_data;
          7: m_ien[63:32]  = m_ien[63:32]  | wr_data;
          8: m_ien[31:0]   = m_ien[31:0]   & ~wr_data;
          9: m_ien[63:32]  = m_ien[63:32]  & ~wr_data;
          default: begin
            if (wr_addr >= 5'd10 && wr_addr <= 5'd17) begin
              if (wr_addr[0] == 1'b0) m_mask[(int'(wr_addr)-10)/2][31:0]  = wr_data;
              else                    m_mask[(int'(wr_addr)-10)/2][63:32] = wr_data;
            end
          end
        endcase
      end
      if (cmpl_valid) m_pend[cmpl_code] = 1'b1;
    end
  end

  // per-cycle comparison against the model, away from the active edge (R6 R7 R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(irq === m_irq, "R6 R7 R8 irq vs model", {28'd0, irq}, {28'd0, m_irq});
      check(rd_data === model_read(int'(rd_addr)), "R2 R4 R5 read vs model", rd_data, model_read(int'(rd_addr)));
      for (int r = 0; r < 4; r++) if (irq[r]) pcnt[r]++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      cmpl_valid = 1'b0; wr_en = 1'b0;
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #5;
    cmpl_valid = 1'b0; wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(posedge clk); #5;
    wr_en = 1'b0;
  endtask

  task automatic cmpl(input int code);
    @(posedge clk); #5;
    wr_en = 1'b0; cmpl_valid = 1'b1; cmpl_code = 6'(code);
    @(posedge clk); #5;
    cmpl_valid = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk); #5;
    rd_addr = 5'(a);
    @(negedge clk);
    check(rd_data === exp, tag, rd_data, exp);
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    for (int r = 0; r < 4; r++) pcnt[r] = 0;
    repeat (4) @(posedge clk);
    #5 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(irq === 4'd0, "R1 irq after reset", {28'd0, irq}, 32'd0);
    check(cmpl_ready === 1'b1, "R1 ready high", {31'd0, cmpl_ready}, 32'd1);
    for (int a = 0; a < 19; a++) rd(a, 32'd0, "R1 register zero after reset");

    // R2 completions in both words
    cmpl(3);
    cmpl(40);
    rd(0, 32'h8, "R2 pending low word");
    rd(1, 32'h100, "R2 pending high word");

    // R4 enable set/clear
    wr(6, 32'hF);
    wr(7, 32'h100);
    rd(4, 32'hF, "R4 enable set low");
    wr(8, 32'h1);
    rd(4, 32'hE, "R4 enable clear low");
    rd(5, 32'h100, "R4 enable high");

    // R5 mask load -> R6 pulse on region 0
    base = pcnt[0];
    wr(10, 32'hC);
    idle(3);
    rd(10, 32'hC, "R5 mask readback region 0");
    check(pcnt[0] == base + 1, "R6 single pulse on rise", pcnt[0], base + 1);

    // R7 extra pending while active: no pulse
    base = pcnt[0];
    cmpl(2);
    idle(3);
    check(pcnt[0] == base, "R7 no pulse while active", pcnt[0], base);

    // R8 evaluate: region 0 active pulses, region 1 inactive does not
    base = pcnt[0];
    wr(18, 32'h1);
    idle(2);
    check(pcnt[0] == base + 1, "R8 eval pulse on active region", pcnt[0], base + 1);
    base = pcnt[1];
    wr(18, 32'h2);
    idle(2);
    check(pcnt[1] == base, "R8 eval ignored on inactive region", pcnt[1], base);
    rd(18, 32'd0, "R8 eval reads zero");

    // R3 clear semantics
    wr(2, 32'h0);
    rd(0, 32'hC, "R3 zero write keeps pending");
    wr(2, 32'h4);
    rd(0, 32'h8, "R3 one clears pending bit");
    wr(2, 32'h8);
    base = pcnt[0];
    cmpl(3);
    idle(3);
    check(pcnt[0] == base + 1, "R6 fresh pulse after going inactive", pcnt[0], base + 1);

    // R9 set beats clear in the same cycle
    @(posedge clk); #5;
    cmpl_valid = 1'b1; cmpl_code = 6'd5; wr_en = 1'b1; wr_addr = 5'd2; wr_data = 32'h20;
    idle(1);
    rd(0, 32'h28, "R9 set wins over clear");

    // R5 high-word mask on region 3
    base = pcnt[3];
    wr(17, 32'h100);
    idle(3);
    rd(17, 32'h100, "R5 mask readback region 3 high");
    check(pcnt[3] == base + 1, "R6 region 3 pulse via high word", pcnt[3], base + 1);

    // mixed stimulus, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #5;
      cmpl_valid = ($urandom % 4) == 0;
      cmpl_code  = 6'($urandom % 64);
      wr_en      = ($urandom % 3) == 0;
      wr_addr    = 5'($urandom % 19);
      wr_data    = $urandom & $urandom & $urandom;
      rd_addr    = 5'($urandom % 19);
    end
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule